// File: doc/BRIEF.md
# Privilege-Gated Serial Register Map

This block is the CPU-facing register and queue-memory decoder of a serial peripheral. It sits on a 16-bit bus, holds the peripheral's control registers and its three queue memories, and checks every read and write against a supervisor-status input.

The address window has two privilege classes. A small global segment holds the configuration, test and interrupt words, and only supervisor accesses reach it. The assignable segment holds the serial control, status, port and direction registers and the receive, transmit and command queues. A lock bit in the configuration word decides whether the assignable segment is supervisor-only or open to every access.

A blocked access raises no error. A blocked read returns zero and a blocked write leaves storage unchanged. Each access takes one cycle. `ready` and the registered read data appear in the cycle after `req`. Addresses are word offsets: the byte offset is `2*waddr`.

Top module: `serial_regmap`

## Requirements
- R1: The global words at byte offsets 0x00 (configuration), 0x02 (test) and 0x04 (interrupt level in the upper byte, vector in the lower byte) are reachable only when `supv` is 1. A user read of them returns 0 and a user write changes nothing.
- R2: Configuration bit 15 is the lock bit. It resets to 1 and is driven out on `priv_lock`. While it is 1, user reads of the assignable segment return 0 and user writes there change nothing.
- R3: While the lock bit is 0, user accesses read and write the assignable registers and queues exactly as supervisor accesses do.
- R4: The lock bit changes only through a supervisor write to offset 0x00. A user write to 0x00 leaves `priv_lock` unchanged.
- R5: Reserved offsets read as 0 and ignore writes for either privilege. The reserved offsets are 0x06 to 0x13, 0x20 to 0xFF, and 0x150 to 0x1FF.
- R6: In `be`, bit 1 enables the upper byte and bit 0 the lower byte. A write with one enable set leaves the other byte of the word unchanged.
- R7: `ready` is 1 exactly in the cycle after a cycle with `req` high. In that cycle `rdata` carries the read value, or 0 for a write or a blocked read. At all other times `rdata` is 0.
- R8: The receive queue spans 0x100 to 0x11F, the transmit queue 0x120 to 0x13F and the command queue 0x140 to 0x14F. Each word is independent storage.
- R9: At 0x14 only the lower byte (port data) is implemented, and the upper byte reads 0. The word at 0x16 holds pin assignment in the upper byte and direction in the lower byte. The serial control words are at 0x18, 0x1A and 0x1C. At 0x1E the upper byte is control and the lower byte is status.
- R10: After reset the configuration word reads 0x8000, and every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access strobe, one access per high cycle |
| wr | input | 1 | 1 for write, 0 for read |
| waddr | input | 8 | Word offset (byte offset / 2) |
| be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| wdata | input | 16 | Write data |
| supv | input | 1 | 1 when the access is supervisor-mode |
| rdata | output | 16 | Registered read data |
| ready | output | 1 | Access complete, one cycle after req |
| priv_lock | output | 1 | Current lock bit of the assignable segment |

## Verification
The bench builds the block with its default queue sizes: 16 receive words, 16 transmit words and 8 command words. With these sizes, the first and last word of every queue sit at fixed byte offsets that the bench can name directly. The first reserved word past the command queue is also directly reachable, so an off-by-one in the range decode turns into a visible aliasing write. The lock bit is toggled both ways within one run, so the same offsets are exercised as locked, open and re-locked.

// File: rtl/srm_pkg.sv
// Package: shared constants and types for the serial register map.
// Assumes a 16-bit data path and word offsets on the address port.
package srm_pkg;
    localparam int DATA_W     = 16;
    localparam int REG_WORDS  = 16;     // word offsets 0x00..0x0F of the register area
    localparam int GLB_LAST   = 2;      // global words 0..2
    localparam int ASG_FIRST  = 10;     // assignable register words 10..15
    localparam int ASG_LAST   = 15;
    localparam int RAM_W_BASE = 'h80;   // byte offset 0x100
    localparam int LOCK_BIT   = 15;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_GLOBAL,
        RG_ASSIGN,
        RG_RX,
        RG_TX,
        RG_CMD
    } region_e;

    // Implemented bits of each register word
    function automatic logic [DATA_W-1:0] word_mask(input int idx);
        if (idx <= GLB_LAST)                return 16'hFFFF;
        else if (idx == ASG_FIRST)          return 16'h00FF;
        else if (idx > ASG_FIRST && idx <= ASG_LAST) return 16'hFFFF;
        else                                return 16'h0000;
    endfunction

    // Reset value of each register word
    function automatic logic [DATA_W-1:0] word_reset(input int idx);
        return (idx == 0) ? (16'h1 << LOCK_BIT) : 16'h0000;
    endfunction
endpackage

// File: rtl/srm_decode.sv
// Module: srm_decode
// Combinational address decoder. Classifies a word offset into a region,
// derives per-region indices, and decides whether the privilege allows it.
// Assumes queue sizes are powers of two of at least two words.
module srm_decode
    import srm_pkg::*;
#(
    parameter int RX_WORDS  = 16,
    parameter int TX_WORDS  = 16,
    parameter int CMD_WORDS = 8,
    localparam int RX_IW  = $clog2(RX_WORDS),
    localparam int TX_IW  = $clog2(TX_WORDS),
    localparam int CMD_IW = $clog2(CMD_WORDS)
) (
    input  logic [7:0]        waddr,
    input  logic              supv,
    input  logic              lock,
    output region_e           region,
    output logic              allowed,
    output logic [3:0]        reg_idx,
    output logic [RX_IW-1:0]  rx_idx,
    output logic [TX_IW-1:0]  tx_idx,
    output logic [CMD_IW-1:0] cmd_idx
);
    localparam int TX_BASE  = RAM_W_BASE + RX_WORDS;
    localparam int CMD_BASE = TX_BASE + TX_WORDS;
    localparam int RAM_END  = CMD_BASE + CMD_WORDS;

    logic [31:0] wa;
    assign wa = 32'(waddr);

    // Region classification from the word offset
    always_comb begin
        region = RG_NONE;
        if (wa <= 32'(GLB_LAST))
            region = RG_GLOBAL;
        else if (wa >= 32'(ASG_FIRST) && wa <= 32'(ASG_LAST))
            region = RG_ASSIGN;
        else if (wa >= 32'(RAM_W_BASE) && wa < 32'(TX_BASE))
            region = RG_RX;
        else if (wa >= 32'(TX_BASE) && wa < 32'(CMD_BASE))
            region = RG_TX;
        else if (wa >= 32'(CMD_BASE) && wa < 32'(RAM_END))
            region = RG_CMD;
    end

    // Privilege check per region
    always_comb begin
        case (region)
            RG_GLOBAL:                   allowed = supv;
            RG_ASSIGN, RG_RX, RG_TX, RG_CMD: allowed = supv | ~lock;
            default:                     allowed = 1'b0;
        endcase
    end

    // Indices inside each storage block
    assign reg_idx = waddr[3:0];
    assign rx_idx  = RX_IW'(wa - 32'(RAM_W_BASE));
    assign tx_idx  = TX_IW'(wa - 32'(TX_BASE));
    assign cmd_idx = CMD_IW'(wa - 32'(CMD_BASE));
endmodule

// File: rtl/srm_regfile.sv
// Module: srm_regfile
// Register words of the global and assignable segments with byte-lane
// writes. Unimplemented bits read as zero. Assumes the decoder has
// already applied the privilege check to we.
module srm_regfile
    import srm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [3:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              lock
);
    logic [DATA_W-1:0] word_all [REG_WORDS];

    // Byte-lane merge of new data into old contents
    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                                 input logic [DATA_W-1:0] new_v,
                                                 input logic [1:0] en);
        logic [DATA_W-1:0] r;
        r[15:8] = en[1] ? new_v[15:8] : old_v[15:8];
        r[7:0]  = en[0] ? new_v[7:0]  : old_v[7:0];
        return r;
    endfunction

    for (genvar i = 0; i < REG_WORDS; i++) begin : g_word
        localparam logic [DATA_W-1:0] MASK = word_mask(i);
        localparam logic [DATA_W-1:0] RSTV = word_reset(i);
        if (MASK == '0) begin : g_hole
            assign word_all[i] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            // Hold one register word; update enabled lanes on a write hit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RSTV;
                else if (we && idx == 4'(i))
                    q <= merge(q, wdata, be) & MASK;
            end
            assign word_all[i] = q;
        end
    end

    assign rdata = word_all[idx];
    assign lock  = word_all[0][LOCK_BIT];
endmodule

// File: rtl/srm_wordram.sv
// Module: srm_wordram
// Small word-wide queue memory with byte-lane writes and combinational
// read. Contents are not reset. Assumes WORDS is a power of two.
module srm_wordram
    import srm_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int IW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [IW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write the enabled byte lanes of the addressed word
    always_ff @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (we && be[l])
                mem[idx][l*8 +: 8] <= wdata[l*8 +: 8];
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/serial_regmap.sv
// Module: serial_regmap
// Top of the privilege-gated register map. Decodes each access, steers
// write enables to the register file or one queue memory, and registers
// the read data with a one-cycle ready strobe. Blocked or reserved
// accesses complete normally, read as zero and write nothing.
module serial_regmap
    import srm_pkg::*;
#(
    parameter int RX_WORDS  = 16,
    parameter int TX_WORDS  = 16,
    parameter int CMD_WORDS = 8,
    localparam int RX_IW  = $clog2(RX_WORDS),
    localparam int TX_IW  = $clog2(TX_WORDS),
    localparam int CMD_IW = $clog2(CMD_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [7:0]        waddr,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              supv,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              priv_lock
);
    region_e            region;
    logic               allowed;
    logic [3:0]         reg_idx;
    logic [RX_IW-1:0]   rx_idx;
    logic [TX_IW-1:0]   tx_idx;
    logic [CMD_IW-1:0]  cmd_idx;
    logic               lock;
    logic               wr_ok;
    logic [DATA_W-1:0]  reg_rd, rx_rd, tx_rd, cmd_rd, rd_val;
    logic [DATA_W-1:0]  rdata_q;
    logic               ready_q;

    srm_decode #(
        .RX_WORDS (RX_WORDS),
        .TX_WORDS (TX_WORDS),
        .CMD_WORDS(CMD_WORDS)
    ) u_decode (
        .waddr  (waddr),
        .supv   (supv),
        .lock   (lock),
        .region (region),
        .allowed(allowed),
        .reg_idx(reg_idx),
        .rx_idx (rx_idx),
        .tx_idx (tx_idx),
        .cmd_idx(cmd_idx)
    );

    assign wr_ok = req && wr && allowed;

    srm_regfile u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_ok && (region == RG_GLOBAL || region == RG_ASSIGN)),
        .be   (be),
        .idx  (reg_idx),
        .wdata(wdata),
        .rdata(reg_rd),
        .lock (lock)
    );

    srm_wordram #(.WORDS(RX_WORDS)) u_rx_ram (
        .clk(clk), .we(wr_ok && region == RG_RX), .be(be),
        .idx(rx_idx), .wdata(wdata), .rdata(rx_rd)
    );

    srm_wordram #(.WORDS(TX_WORDS)) u_tx_ram (
        .clk(clk), .we(wr_ok && region == RG_TX), .be(be),
        .idx(tx_idx), .wdata(wdata), .rdata(tx_rd)
    );

    srm_wordram #(.WORDS(CMD_WORDS)) u_cmd_ram (
        .clk(clk), .we(wr_ok && region == RG_CMD), .be(be),
        .idx(cmd_idx), .wdata(wdata), .rdata(cmd_rd)
    );

    // Select the read source for the decoded region
    always_comb begin
        case (region)
            RG_GLOBAL, RG_ASSIGN: rd_val = reg_rd;
            RG_RX:                rd_val = rx_rd;
            RG_TX:                rd_val = tx_rd;
            RG_CMD:               rd_val = cmd_rd;
            default:              rd_val = '0;
        endcase
    end

    // Register read data and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            rdata_q <= (req && !wr && allowed) ? rd_val : '0;
            ready_q <= req;
        end
    end

    assign rdata     = rdata_q;
    assign ready     = ready_q;
    assign priv_lock = lock;
endmodule

// File: rtl/serial_regmap_chk.sv
// Module: serial_regmap_chk
// Protocol and privilege checks on the ports of serial_regmap, bound in.
module serial_regmap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        wr,
    input logic [7:0]  waddr,
    input logic        supv,
    input logic [15:0] rdata,
    input logic        ready,
    input logic        priv_lock
);
    assert_ready_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ready);

    assert_ready_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(req));

    assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> rdata == 16'h0);

    assert_user_global_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !supv && waddr < 8'd4) |=> rdata == 16'h0);

    assert_locked_user_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !supv && priv_lock && waddr >= 8'd10) |=> rdata == 16'h0);

    assert_user_write_keeps_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && !supv) |=> priv_lock == $past(priv_lock));

    assert_reserved_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && waddr >= 8'hA8) |=> rdata == 16'h0);
endmodule

bind serial_regmap serial_regmap_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .waddr    (waddr),
    .supv     (supv),
    .rdata    (rdata),
    .ready    (ready),
    .priv_lock(priv_lock)
);

// File: tb/serial_regmap_tb.sv
// Scoreboard bench: the driver task queues the expected response of each
// access, the monitor pops and compares at each ready strobe.
module serial_regmap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  waddr = '0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic        supv = 1'b0;
    logic [15:0] rdata;
    logic        ready;
    logic        priv_lock;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    serial_regmap u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .waddr(waddr),
        .be(be), .wdata(wdata), .supv(supv), .rdata(rdata),
        .ready(ready), .priv_lock(priv_lock)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access at a byte offset; queues the expected ready-cycle rdata
    task automatic acc(input bit w, input int off, input logic [1:0] b,
                       input logic [15:0] d, input bit s, input logic [15:0] exp,
                       input string tag);
        @(negedge clk);
        req = 1'b1; wr = w; waddr = 8'(off >> 1); be = b; wdata = d; supv = s;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Monitor: compare each completed access against the queue
    always @(negedge clk) begin
        if (rst_n && ready) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected ready", 16'h1, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 lock after reset", 16'(priv_lock), 16'h1);
        check("R7 ready idle", 16'(ready), 16'h0);
        check("R7 rdata idle", rdata, 16'h0);

        acc(0, 'h00, 2'b11, 0, 1, 16'h8000, "R10 config reset");
        acc(0, 'h1A, 2'b11, 0, 1, 16'h0000, "R10 control reset");
        // R1 global words
        acc(1, 'h02, 2'b11, 16'h1234, 1, 0, "R7 write ack");
        acc(0, 'h02, 2'b11, 0, 1, 16'h1234, "R1 sup read test");
        acc(0, 'h02, 2'b11, 0, 0, 16'h0000, "R1 user read test");
        acc(1, 'h02, 2'b11, 16'hFFFF, 0, 0, "R7 write ack");
        acc(0, 'h02, 2'b11, 0, 1, 16'h1234, "R1 user write ignored");
        acc(1, 'h04, 2'b11, 16'h0540, 1, 0, "R7 write ack");
        acc(0, 'h04, 2'b11, 0, 1, 16'h0540, "R1 irq word");
        // R2 locked assignable segment
        acc(0, 'h18, 2'b11, 0, 0, 16'h0000, "R2 locked user read");
        acc(1, 'h18, 2'b11, 16'hA5A5, 1, 0, "R7 write ack");
        acc(1, 'h18, 2'b11, 16'h1111, 0, 0, "R7 write ack");
        acc(0, 'h18, 2'b11, 0, 1, 16'hA5A5, "R2 locked user write ignored");
        acc(0, 'h18, 2'b11, 0, 0, 16'h0000, "R2 locked user read after write");
        // R4 user cannot clear lock
        acc(1, 'h00, 2'b11, 16'h0000, 0, 0, "R7 write ack");
        check("R4 user write keeps lock", 16'(priv_lock), 16'h1);
        acc(1, 'h00, 2'b11, 16'h0000, 1, 0, "R7 write ack");
        check("R4 sup write clears lock", 16'(priv_lock), 16'h0);
        // R3 open segment
        acc(0, 'h18, 2'b11, 0, 0, 16'hA5A5, "R3 user read open");
        acc(1, 'h1A, 2'b11, 16'h5555, 0, 0, "R7 write ack");
        acc(0, 'h1A, 2'b11, 0, 0, 16'h5555, "R3 user write open");
        acc(0, 'h00, 2'b11, 0, 0, 16'h0000, "R1 global still privileged");
        // R6 byte lanes
        acc(1, 'h16, 2'b11, 16'hABCD, 1, 0, "R7 write ack");
        acc(1, 'h16, 2'b10, 16'h12FF, 1, 0, "R7 write ack");
        acc(0, 'h16, 2'b11, 0, 1, 16'h12CD, "R6 upper lane only");
        acc(1, 'h16, 2'b01, 16'hFF34, 0, 0, "R7 write ack");
        acc(0, 'h16, 2'b11, 0, 1, 16'h1234, "R6 lower lane only");
        // R9 partial words
        acc(1, 'h14, 2'b11, 16'hFFFF, 1, 0, "R7 write ack");
        acc(0, 'h14, 2'b11, 0, 1, 16'h00FF, "R9 port byte only");
        acc(1, 'h1E, 2'b01, 16'hFF3C, 1, 0, "R7 write ack");
        acc(0, 'h1E, 2'b11, 0, 1, 16'h003C, "R9 status low byte");
        // R8 queue ends
        acc(1, 'h100, 2'b11, 16'h1111, 0, 0, "R7 write ack");
        acc(1, 'h11E, 2'b11, 16'h2222, 0, 0, "R7 write ack");
        acc(1, 'h120, 2'b11, 16'h3333, 0, 0, "R7 write ack");
        acc(1, 'h13E, 2'b11, 16'h4444, 0, 0, "R7 write ack");
        acc(1, 'h140, 2'b11, 16'h5555, 0, 0, "R7 write ack");
        acc(1, 'h14E, 2'b11, 16'h6666, 0, 0, "R7 write ack");
        acc(0, 'h100, 2'b11, 0, 0, 16'h1111, "R8 rx first");
        acc(0, 'h11E, 2'b11, 0, 0, 16'h2222, "R8 rx last");
        acc(0, 'h120, 2'b11, 0, 0, 16'h3333, "R8 tx first");
        acc(0, 'h13E, 2'b11, 0, 0, 16'h4444, "R8 tx last");
        acc(0, 'h140, 2'b11, 0, 0, 16'h5555, "R8 cmd first");
        acc(0, 'h14E, 2'b11, 0, 0, 16'h6666, "R8 cmd last");
        // R5 reserved offsets
        acc(1, 'h150, 2'b11, 16'hFFFF, 1, 0, "R7 write ack");
        acc(0, 'h150, 2'b11, 0, 1, 16'h0000, "R5 reserved past cmd");
        acc(0, 'h140, 2'b11, 0, 1, 16'h5555, "R5 no alias to cmd");
        acc(1, 'h08, 2'b11, 16'hFFFF, 1, 0, "R7 write ack");
        acc(0, 'h08, 2'b11, 0, 1, 16'h0000, "R5 reserved low");
        acc(0, 'h06, 2'b11, 0, 1, 16'h0000, "R5 reserved after irq");
        acc(1, 'h40, 2'b11, 16'hFFFF, 1, 0, "R7 write ack");
        acc(0, 'h40, 2'b11, 0, 1, 16'h0000, "R5 reserved mid");
        acc(0, 'h00, 2'b11, 0, 1, 16'h0000, "R5 reserved write left config");
        // R2 re-lock
        acc(1, 'h00, 2'b10, 16'h8000, 1, 0, "R7 write ack");
        check("R2 lock set again", 16'(priv_lock), 16'h1);
        acc(0, 'h100, 2'b11, 0, 0, 16'h0000, "R2 locked queue read");
        acc(1, 'h100, 2'b11, 16'h0000, 0, 0, "R7 write ack");
        acc(0, 'h100, 2'b11, 0, 1, 16'h1111, "R2 locked queue write ignored");

        repeat (3) @(negedge clk);
        while (exp_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            void'(exp_q.pop_front());
            check({"R7 missing ready ", t}, 16'h0, 16'h1);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule